// File: doc/BRIEF.md
# External Bus Interface Controller

This block connects a 16-bit internal request port to an external memory bus. The external bus has four chip-select spaces. The fixed address windows of the request select the space. Each space has its own external data width, 8 or 16 bits, and its own wait-state count. A global format field chooses how addresses go out. In the separate format, addresses and data use separate pins. In the time-multiplexed format, the low address bits share the data lines during a one-clock address phase, which is marked by an address-latch strobe.

A request is a word address, a write flag, two byte enables and 16 bits of write data. The block accepts a request only when it is idle. It runs one or two external byte or word cycles and then returns a one-cycle response. A 16-bit request to an 8-bit space becomes two byte cycles, and the two bytes are joined again before the response. The configuration arrives as plain inputs. It is loaded on a strobe, and every transaction uses the configuration that was loaded when the transaction was accepted.

Top module: `ext_bus_ctrl`

## Requirements
- R1: Request word address bit AW-1 set selects a space, and bits AW-2..AW-3 give the space number, which drives only bus_cs_n[space] low during the bus cycles. If bit AW-1 is clear, or if req_be is 00, the request produces no bus cycle. It completes with rsp_valid and rsp_err high in the first cycle after acceptance.
- R2: Reset state: spaces 0 to 2 are 8-bit, space 3 is 16-bit when byte_strap is 0 and 8-bit when it is 1, every wait count is 3, and the format is 00.
- R3: In each byte or word cycle, the read or write strobe is low for 1 + w clocks, where w is the space's 2-bit field cfg_wait[2i+1:2i]. rsp_valid rises in the clock after the last strobe clock, so latency = n*(m+1+w)+1. Here n is the number of cycles (1 or 2) and m is 1 in multiplexed format and 0 otherwise.
- R4: cfg_fmt encodes the format. 00 makes every space separate. 01 multiplexes space 1 only. 10 multiplexes space 2 only. 11 multiplexes all four spaces.
- R5: A multiplexed cycle begins with one clock of bus_ale high and no strobe. In that clock, bus_dout carries the low 16 byte-address bits (16-bit space) or the low 8 bits with bus_dout[15:8] zero (8-bit space). Those bits read as zero on bus_addr during the cycle.
- R6: In the separate format, bus_ale stays low and bus_addr carries the full byte address throughout the cycle.
- R7: From reset until the first cfg_wr pulse, every access uses the separate format, whatever cfg_fmt holds.
- R8: On an 8-bit space, req_be 11 gives two byte cycles, low byte first, at byte address bit 0 = 0 and then 1. req_be 01 gives one cycle at bit 0 = 0, and 10 gives one cycle at bit 0 = 1. All bytes travel on lane 0 (bus_dout[7:0] / bus_din[7:0]).
- R9: On a 16-bit space, every access is a single cycle at byte address bit 0 = 0, with bus_be_n = ~req_be. On an 8-bit space, bus_be_n is 10 during strobes.
- R10: rsp_rdata holds the read bytes in their lanes, and zero in lanes that are not enabled. Write responses and error responses return zero. bus_din[15:8] has no effect on reads from 8-bit spaces.
- R11: hi_lane_gpio is high exactly when all four spaces are set to 8 bits.
- R12: A cfg_wr during a transaction leaves that transaction's timing unchanged. The new values apply from the next accepted request.
- R13: req_ready is high only when the block is idle with no chip select active, so at most one transaction is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_strap | input | 1 | Reset width strap for space 3 (1 = 8-bit) |
| cfg_wr | input | 1 | Load strobe for the configuration inputs |
| cfg_wide | input | 4 | Per-space width, 1 = 16-bit |
| cfg_wait | input | 8 | Per-space 2-bit wait counts |
| cfg_fmt | input | 2 | Bus format select |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | AW-1 | Word address (byte address bits AW-1..1) |
| req_we | input | 1 | 1 = write |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is an address or enable error |
| rsp_rdata | output | 16 | Read data |
| bus_cs_n | output | 4 | Chip selects, active low |
| bus_addr | output | AW | External byte address |
| bus_ale | output | 1 | Address-latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_be_n | output | 2 | Byte lane enables, active low |
| bus_dout | output | 16 | Outgoing address/data lines |
| bus_doe | output | 1 | Drive enable for bus_dout |
| bus_din | input | 16 | Incoming data lines |
| hi_lane_gpio | output | 1 | Upper data lane free for general I/O |

## Verification
The assertions assume that byte_strap is stable from reset onward and that rst_n is low at time zero. They also assume that bus_din settles while the strobe is low, because the block samples it on the last strobe clock. The stimulus meets these assumptions. The bench sets the strap only while reset is held. It raises requests only after a response has retired. It models the external device combinationally from the chip selects, the latched address and the bus address. That model returns 8'hA5 on the upper lane of 8-bit spaces, so any use of that lane would show up in the data.

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_strap,
  input  logic          cfg_wr,
  input  logic [3:0]    cfg_wide,
  input  logic [7:0]    cfg_wait,
  input  logic [1:0]    cfg_fmt,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:1] req_addr,
  input  logic          req_we,
  input  logic [1:0]    req_be,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [15:0]   rsp_rdata,
  output logic [3:0]    bus_cs_n,
  output logic [AW-1:0] bus_addr,
  output logic          bus_ale,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [1:0]    bus_be_n,
  output logic [15:0]   bus_dout,
  output logic          bus_doe,
  input  logic [15:0]   bus_din,
  output logic          hi_lane_gpio
);

  typedef enum logic [1:0] {IDLE, ADR, DAT, RSP} st_t;
  st_t st;

  logic [3:0]    wide_r;
  logic [7:0]    wait_r;
  logic [1:0]    fmt_r;

  logic [1:0]    sp;
  logic [AW-1:1] a;
  logic          we, wide, mux, lane, two, err;
  logic [1:0]    be, wt, cnt;
  logic [15:0]   wd, rd;

  wire [1:0] nsp  = req_addr[AW-2:AW-3];
  wire       hit  = req_addr[AW-1] && (req_be != 2'b00);
  wire       nmux = (fmt_r == 2'b11) || (fmt_r == 2'b01 && nsp == 2'd1) ||
                    (fmt_r == 2'b10 && nsp == 2'd2);
  wire [1:0] nwt  = wait_r[2*nsp +: 2];
  wire       nwide = wide_r[nsp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide_r <= {~byte_strap, 3'b000};
      wait_r <= 8'hFF;
      fmt_r  <= 2'b00;
    end else if (cfg_wr) begin
      wide_r <= cfg_wide;
      wait_r <= cfg_wait;
      fmt_r  <= cfg_fmt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      sp <= '0; a <= '0; we <= 1'b0; be <= '0; wd <= '0; rd <= '0;
      wide <= 1'b0; mux <= 1'b0; lane <= 1'b0; two <= 1'b0; err <= 1'b0;
      wt <= '0; cnt <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          rd <= '0;
          sp <= nsp; a <= req_addr; we <= req_we; be <= req_be; wd <= req_wdata;
          wide <= nwide; mux <= nmux; wt <= nwt; cnt <= nwt;
          lane <= !nwide && req_be == 2'b10;
          two  <= !nwide && req_be == 2'b11;
          err  <= !hit;
          st   <= !hit ? RSP : (nmux ? ADR : DAT);
        end
        ADR: begin
          cnt <= wt;
          st  <= DAT;
        end
        DAT: if (cnt != 2'd0) begin
          cnt <= cnt - 2'd1;
        end else begin
          if (!we) begin
            if (wide)      rd <= bus_din & {{8{be[1]}}, {8{be[0]}}};
            else if (lane) rd[15:8] <= bus_din[7:0];
            else           rd[7:0]  <= bus_din[7:0];
          end
          if (two) begin
            two  <= 1'b0;
            lane <= 1'b1;
            cnt  <= wt;
            st   <= mux ? ADR : DAT;
          end else begin
            st <= RSP;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  wire          act   = (st == ADR) || (st == DAT);
  wire [AW-1:0] ea    = {a, wide ? 1'b0 : lane};
  wire [15:0]   lmask = !mux ? 16'h0000 : (wide ? 16'hFFFF : 16'h00FF);
  wire [7:0]    wbyte = lane ? wd[15:8] : wd[7:0];

  assign req_ready    = (st == IDLE);
  assign rsp_valid    = (st == RSP);
  assign rsp_err      = (st == RSP) && err;
  assign rsp_rdata    = rd;
  assign bus_cs_n     = act ? ~(4'b0001 << sp) : 4'b1111;
  assign bus_addr     = act ? (ea & ~{{(AW-16){1'b0}}, lmask}) : '0;
  assign bus_ale      = (st == ADR);
  assign bus_rd_n     = !((st == DAT) && !we);
  assign bus_wr_n     = !((st == DAT) && we);
  assign bus_be_n     = (st != DAT) ? 2'b11 : (wide ? ~be : 2'b10);
  assign bus_doe      = (st == ADR) || ((st == DAT) && we);
  assign bus_dout     = (st == ADR) ? (ea[15:0] & lmask) :
                        ((st == DAT) && we) ? (wide ? wd : {8'h00, wbyte}) : 16'h0000;
  assign hi_lane_gpio = (wide_r == 4'b0000);

endmodule

// File: rtl/ext_bus_ctrl_chk.sv
module ext_bus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic [3:0] bus_cs_n,
  input logic       bus_ale,
  input logic       bus_rd_n,
  input logic       bus_wr_n,
  input logic [1:0] bus_be_n,
  input logic       hi_lane_gpio
);

  logic cfg_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_seen <= 1'b0;
    else if (cfg_wr) cfg_seen <= 1'b1;
  end

  a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  a_r1_err_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  a_r1_rsp_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (&bus_cs_n && bus_rd_n && bus_wr_n));
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_n || bus_wr_n);
  a_r3_strobe_before_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> $past(!bus_rd_n || !bus_wr_n));
  a_r5_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n && !(&bus_cs_n)));
  a_r5_ale_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> (!bus_ale && (!bus_rd_n || !bus_wr_n)));
  a_r7_separate_until_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_seen |-> !bus_ale);
  a_r11_upper_lane_unused: assert property (@(posedge clk) disable iff (!rst_n)
    hi_lane_gpio |-> bus_be_n[1]);
  a_r13_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&bus_cs_n && !rsp_valid));

endmodule

bind ext_bus_ctrl ext_bus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .bus_cs_n(bus_cs_n),
  .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
  .bus_be_n(bus_be_n), .hi_lane_gpio(hi_lane_gpio)
);

// File: tb/tb_ext_bus_ctrl.sv
module tb_ext_bus_ctrl;
  localparam int AW = 20;

  logic clk = 1'b0, rst_n = 1'b0, byte_strap = 1'b1;
  logic cfg_wr = 1'b0;
  logic [3:0] cfg_wide = '0;
  logic [7:0] cfg_wait = '0;
  logic [1:0] cfg_fmt = '0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:1] req_addr = '0;
  logic [1:0] req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, bus_ale, bus_rd_n, bus_wr_n, bus_doe, hi_lane_gpio;
  logic [15:0] rsp_rdata, bus_dout, bus_din;
  logic [3:0] bus_cs_n;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_be_n;

  ext_bus_ctrl #(.AW(AW)) dut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  logic [3:0] cur_wide;
  logic [7:0] cur_wait;
  logic [1:0] cur_fmt;
  int last_ale, last_lat;

  logic [7:0] dmem [0:255];
  logic [7:0] rmem [0:255];
  logic [15:0] lat;
  logic [AW-1:0] dev_addr;
  logic [1:0] dsp;
  logic dany;

  assign dev_addr = bus_addr | {4'b0000, lat};

  always_comb begin
    dsp = 2'd0; dany = 1'b0;
    for (int i = 0; i < 4; i++) if (!bus_cs_n[i]) begin dsp = 2'(i); dany = 1'b1; end
    bus_din = 16'h0000;
    if (dany) begin
      if (cur_wide[dsp]) bus_din = {dmem[{dsp, dev_addr[5:1], 1'b1}], dmem[{dsp, dev_addr[5:1], 1'b0}]};
      else               bus_din = {8'hA5, dmem[{dsp, dev_addr[5:0]}]};
    end
  end

  always @(negedge clk) begin
    if (!rst_n || rsp_valid) lat <= 16'h0000;
    else if (bus_ale) lat <= bus_dout;
    if (rst_n && !bus_wr_n && dany) begin
      if (cur_wide[dsp]) begin
        if (!bus_be_n[0]) dmem[{dsp, dev_addr[5:1], 1'b0}] = bus_dout[7:0];
        if (!bus_be_n[1]) dmem[{dsp, dev_addr[5:1], 1'b1}] = bus_dout[15:8];
      end else dmem[{dsp, dev_addr[5:0]}] = bus_dout[7:0];
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic mux_of(input logic [1:0] f, input logic [1:0] s);
    return (f == 2'b11) || (f == 2'b01 && s == 2'd1) || (f == 2'b10 && s == 2'd2);
  endfunction

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; byte_strap = strap; req_valid = 1'b0; cfg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_wide = {~strap, 3'b000}; cur_wait = 8'hFF; cur_fmt = 2'b00;
  endtask

  task automatic set_cfg(input logic [3:0] w, input logic [7:0] t, input logic [1:0] f);
    @(negedge clk);
    cfg_wide = w; cfg_wait = t; cfg_fmt = f; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    cur_wide = w; cur_wait = t; cur_fmt = f;
  endtask

  task automatic xfer(input logic [AW-1:1] addr, input logic we, input logic [1:0] be,
                      input logic [15:0] wd, input logic midcfg, input logic [7:0] nwait);
    int k, alec, stbc, n, p, m, w;
    logic bad_cs, bad_addr, bad_rdy, bad_be, seen, fl, ll, hitx, wide;
    logic [1:0] s;
    logic [15:0] expd, mask;
    s = addr[AW-2:AW-3];
    hitx = addr[AW-1] && be != 2'b00;
    wide = cur_wide[s];
    w = int'(cur_wait[2*s +: 2]);
    m = mux_of(cur_fmt, s) ? 1 : 0;
    n = (!wide && be == 2'b11) ? 2 : 1;
    p = m + 1 + w;
    mask = (m == 0) ? 16'h0000 : (wide ? 16'hFFFF : 16'h00FF);
    alec = 0; stbc = 0; bad_cs = 0; bad_addr = 0; bad_rdy = 0; bad_be = 0; seen = 0; fl = 0; ll = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_we = we; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!rsp_valid && k < 64) begin
      if (midcfg && k == 1) begin cfg_wait = nwait; cfg_wr = 1'b1; end
      if (req_ready) bad_rdy = 1;
      if (bus_ale) alec++;
      if (!hitx && bus_cs_n != 4'b1111) bad_cs = 1;
      if (!bus_rd_n || !bus_wr_n) begin
        stbc++;
        if (bus_cs_n != ~(4'b0001 << s)) bad_cs = 1;
        if (dev_addr[AW-1:1] != addr) bad_addr = 1;
        if ((bus_addr[15:0] & mask) != 16'h0000) bad_addr = 1;
        if (m == 0 && lat != 16'h0000) bad_addr = 1;
        if (bus_be_n != (wide ? ~be : 2'b10)) bad_be = 1;
        if (!seen) fl = dev_addr[0];
        ll = dev_addr[0]; seen = 1;
      end
      @(negedge clk);
      if (midcfg && k == 1) cfg_wr = 1'b0;
      k++;
    end
    if (midcfg) cur_wait = nwait;
    last_ale = alec; last_lat = k;
    if (!hitx) begin
      chk(k == 1, "R1 error latency", k, 1);
      chk(rsp_err == 1'b1, "R1 error flag", rsp_err, 1);
      chk(stbc == 0 && !bad_cs, "R1 no bus cycle", stbc, 0);
      chk(rsp_rdata == 16'h0, "R10 error data", rsp_rdata, 0);
      return;
    end
    chk(k == n*p + 1, "R3 latency", k, n*p + 1);
    chk(stbc == n*(1 + w), "R3 strobe clocks", stbc, n*(1 + w));
    chk(alec == n*m, "R4 R5 address phases", alec, n*m);
    chk(!bad_cs && !rsp_err, "R1 chip select", bus_cs_n, ~(4'b0001 << s));
    chk(!bad_addr, "R5 R6 bus address", {bad_addr, addr}, {1'b0, addr});
    chk(!bad_be, "R9 byte enables", bad_be, 0);
    chk(!bad_rdy, "R13 ready while busy", bad_rdy, 0);
    chk(fl == (!wide && be == 2'b10) && ll == (!wide && be[1]), "R8 byte order",
        {fl, ll}, {(!wide && be == 2'b10), (!wide && be[1])});
    expd = 16'h0000;
    for (int j = 0; j < 2; j++) if (be[j]) begin
      if (we) rmem[{s, addr[5:1], 1'(j)}] = (j == 0) ? wd[7:0] : wd[15:8];
      else if (j == 0) expd[7:0] = rmem[{s, addr[5:1], 1'b0}];
      else expd[15:8] = rmem[{s, addr[5:1], 1'b1}];
    end
    chk(rsp_rdata == expd, "R10 R8 response data", rsp_rdata, expd);
  endtask

  function automatic logic [AW-1:1] mk_addr(input logic [1:0] s, input int id);
    logic [7:0] mid; logic [4:0] off;
    mid = 8'(id * 29); off = 5'(id * 7);
    return {1'b1, s, 3'b000, mid, off};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) begin dmem[i] = 8'(i*7 + 3); rmem[i] = 8'(i*7 + 3); end
    lat = 16'h0000;
    do_reset(1'b1);
    @(negedge clk);
    chk(bus_cs_n == 4'b1111 && bus_rd_n && bus_wr_n && !bus_ale, "R2 reset bus idle", bus_cs_n, 4'hF);
    chk(req_ready == 1'b1 && !rsp_valid, "R13 reset ready", req_ready, 1);
    chk(hi_lane_gpio == 1'b1, "R2 R11 strap high all narrow", hi_lane_gpio, 1);
    cfg_fmt = 2'b11; cfg_wide = 4'b1111; cfg_wait = 8'h00;
    xfer(mk_addr(2'd3, 1), 1'b0, 2'b11, 16'h0, 1'b0, 8'h0);
    chk(last_ale == 0, "R7 separate before cfg", last_ale, 0);
    chk(last_lat == 9, "R2 space3 narrow wait3", last_lat, 9);
    xfer(mk_addr(2'd1, 2), 1'b1, 2'b11, 16'hBEEF, 1'b0, 8'h0);
    chk(last_ale == 0, "R7 separate before cfg space1", last_ale, 0);

    for (int f = 0; f < 4; f++)
      for (int wp = 0; wp < 4; wp++) begin
        logic [3:0] wpat; logic [7:0] wt;
        wpat = (wp == 0) ? 4'b0000 : (wp == 1) ? 4'b1111 : (wp == 2) ? 4'b0101 : 4'b1010;
        for (int i = 0; i < 4; i++) wt[2*i +: 2] = 2'((i + f + wp) % 4);
        set_cfg(wpat, wt, 2'(f));
        chk(hi_lane_gpio == (wpat == 4'b0000), "R11 upper lane flag", hi_lane_gpio, (wpat == 4'b0000));
        for (int s = 0; s < 4; s++)
          for (int b = 1; b < 4; b++) begin
            int id;
            id = ((f*4 + wp)*4 + s)*3 + b;
            xfer(mk_addr(2'(s), id), 1'b1, 2'(b), 16'(id*16'h1357 + 16'h2468), 1'b0, 8'h0);
            xfer(mk_addr(2'(s), id), 1'b0, 2'(b), 16'h0, 1'b0, 8'h0);
          end
      end

    xfer({1'b0, 18'h1234}, 1'b0, 2'b11, 16'h0, 1'b0, 8'h0);
    xfer({1'b0, 18'h3FFFF}, 1'b1, 2'b01, 16'h55AA, 1'b0, 8'h0);
    xfer(mk_addr(2'd2, 9), 1'b0, 2'b00, 16'h0, 1'b0, 8'h0);

    set_cfg(4'b1111, 8'h00, 2'b00);
    xfer(mk_addr(2'd0, 5), 1'b0, 2'b11, 16'h0, 1'b1, 8'hFF);
    chk(last_lat == 2, "R12 in-flight keeps old waits", last_lat, 2);
    xfer(mk_addr(2'd0, 5), 1'b0, 2'b11, 16'h0, 1'b0, 8'h0);
    chk(last_lat == 5, "R12 next request uses new waits", last_lat, 5);

    do_reset(1'b0);
    @(negedge clk);
    chk(hi_lane_gpio == 1'b0, "R2 R11 strap low", hi_lane_gpio, 0);
    xfer(mk_addr(2'd3, 7), 1'b0, 2'b11, 16'h0, 1'b0, 8'h0);
    chk(last_lat == 5, "R2 space3 wide after strap low", last_lat, 5);
    xfer(mk_addr(2'd0, 8), 1'b0, 2'b11, 16'h0, 1'b0, 8'h0);
    chk(last_lat == 9, "R2 space0 narrow at reset", last_lat, 9);

    summary();
    $finish;
  end
endmodule